// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data word into one asynchronous serial frame on a single TX line. A set of control inputs selects the frame format for each word: 5 to 8 data bits, an optional parity bit (odd, even, or a fixed value), and one or two stop bits. The format and the data are captured when the word is accepted, so the control inputs may change while a frame is on the line without disturbing it.

Words arrive over a valid/ready handshake. A one-cycle baud tick enable sets the bit rate, and each serial bit lasts exactly one tick. A flow-control option can hold back each new frame until an external clear-to-send input is active, so a remote receiver can pause the link. A frame that has already started always runs to its end. The busy output covers the whole time from acceptance to the end of the last stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: With every control input at 0, a frame carries 5 data bits, no parity bit and one stop bit. After reset the line is high, busy is low and ready is high.
- R2: The line idles high. A frame is a low start bit, then the data bits, then the parity bit if parity is enabled, then the stop bits, which are high. Each bit starts on a baud tick and lasts until the next tick. The start bit begins on the first tick after the acceptance edge. A tick sampled on the acceptance edge itself does not start the frame.
- R3: The word-length code `cfg_wls` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data goes out least significant bit first. Bits above the selected length are not sent and do not affect parity.
- R4: With `cfg_par_en` at 0, the first stop bit follows the last data bit directly. With `cfg_par_en` at 1, one parity bit sits between the data bits and the stop bits.
- R5: With stick off, `cfg_par_even`=1 makes the number of ones in the data bits plus the parity bit even, and `cfg_par_even`=0 makes it odd.
- R6: With `cfg_par_stick`=1 and parity enabled, the parity bit equals `cfg_par_even`, whatever the data.
- R7: `cfg_two_stop`=0 gives one stop bit and `cfg_two_stop`=1 gives two.
- R8: With `cfg_cts_en`=1 and `cts_ok` low, no word is accepted and the line stays idle. With `cfg_cts_en`=0, `cts_ok` has no effect.
- R9: If `cts_ok` goes low after a frame has started, that frame still completes unchanged.
- R10: `in_ready` is high only while no frame is pending or in progress. `tx_busy` rises on the acceptance edge and falls on the tick that ends the last stop bit.
- R11: Data and format are sampled on the acceptance edge. Changes to `in_data` or to the format inputs during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Word to send |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted this cycle |
| baud_tick | input | 1 | One-cycle bit-rate enable |
| cfg_wls | input | 2 | Word length code (5 + code bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even, 0 odd; stick value when stick is set |
| cfg_par_stick | input | 1 | Parity bit fixed to `cfg_par_even` |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_cts_en | input | 1 | Gate frame starts on `cts_ok` |
| cts_ok | input | 1 | Remote end clear to send, active high |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame pending or in progress |

## Verification
Two events can fall in the same cycle: the acceptance of a word and a baud tick. The bench provokes this by raising `in_valid` in exactly the cycle where the tick is high. It then checks that the line is still high after that edge and that the start bit appears only on the following tick, with a full-length frame behind it. A second coincidence is a change of `cts_ok` or of the format inputs while a frame is running. It is judged by comparing every serial bit with the frame expected from the values present at acceptance.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_START  = 3'd2,
    ST_DATA   = 3'd3,
    ST_PARITY = 3'd4,
    ST_STOP   = 3'd5
  } uft_state_e;

  typedef struct packed {
    logic [1:0] wls;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       two_stop;
  } uft_fmt_t;

endpackage

// File: rtl/uft_parity.sv
module uft_parity #(
  parameter int DATA_W   = 8,
  parameter int MIN_WORD = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wls,
  input  logic              par_even,
  input  logic              par_stick,
  output logic [DATA_W-1:0] data_masked,
  output logic              par_bit
);

  logic [DATA_W-1:0] keep;
  logic              ones_odd;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_keep
      assign keep[gi] = ((int'(wls) + MIN_WORD) > gi);
    end
  endgenerate

  assign data_masked = data & keep;
  assign ones_odd    = ^data_masked;

  always_comb begin
    if (par_stick)     par_bit = par_even;
    else if (par_even) par_bit = ones_odd;
    else               par_bit = ~ones_odd;
  end

endmodule

// File: rtl/uft_seq.sv
module uft_seq
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              accept,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [CNT_W-1:0]  ld_last,
  input  logic              ld_par_en,
  input  logic              ld_par_bit,
  input  logic              ld_two_stop,
  output uft_state_e        state_o,
  output logic              tx_line,
  output logic              tx_busy
);

  uft_state_e        state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  last_idx;
  logic              par_en_q;
  logic              par_q;
  logic              two_stop_q;
  logic              stop_idx;

  assign state_o = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bit_idx    <= '0;
      last_idx   <= '0;
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
      two_stop_q <= 1'b0;
      stop_idx   <= 1'b0;
      tx_line    <= 1'b1;
      tx_busy    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            shreg      <= ld_data;
            last_idx   <= ld_last;
            par_en_q   <= ld_par_en;
            par_q      <= ld_par_bit;
            two_stop_q <= ld_two_stop;
            tx_busy    <= 1'b1;
            state      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (tick) begin
            tx_line <= 1'b0;
            state   <= ST_START;
          end
        end
        ST_START: begin
          if (tick) begin
            tx_line <= shreg[0];
            shreg   <= shreg >> 1;
            bit_idx <= '0;
            state   <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (bit_idx == last_idx) begin
              if (par_en_q) begin
                tx_line <= par_q;
                state   <= ST_PARITY;
              end else begin
                tx_line  <= 1'b1;
                stop_idx <= 1'b0;
                state    <= ST_STOP;
              end
            end else begin
              tx_line <= shreg[0];
              shreg   <= shreg >> 1;
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        ST_PARITY: begin
          if (tick) begin
            tx_line  <= 1'b1;
            stop_idx <= 1'b0;
            state    <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (two_stop_q && !stop_idx) begin
              stop_idx <= 1'b1;
            end else begin
              tx_busy <= 1'b0;
              state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the data bit index never passes the latched last position
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> (bit_idx <= last_idx));

  // R7: a second stop bit is only entered when two stops were latched
  a_r7_second_stop: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP && stop_idx) |-> two_stop_q);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              baud_tick,
  input  logic [1:0]        cfg_wls,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_two_stop,
  input  logic              cfg_cts_en,
  input  logic              cts_ok,
  output logic              tx_line,
  output logic              tx_busy
);

  localparam int MIN_WORD = DATA_W - 3;
  localparam int CNT_W    = $clog2(DATA_W);

  uft_fmt_t          fmt;
  uft_state_e        state;
  logic              accept;
  logic [DATA_W-1:0] data_masked;
  logic              par_bit;
  logic [CNT_W-1:0]  last_idx;

  assign fmt = '{wls: cfg_wls, par_en: cfg_par_en, par_even: cfg_par_even,
                 par_stick: cfg_par_stick, two_stop: cfg_two_stop};

  assign in_ready = (state == ST_IDLE) && (!cfg_cts_en || cts_ok);
  assign accept   = in_valid && in_ready;
  assign last_idx = CNT_W'(MIN_WORD - 1) + CNT_W'(fmt.wls);

  uft_parity #(.DATA_W(DATA_W), .MIN_WORD(MIN_WORD)) u_parity (
    .data        (in_data),
    .wls         (fmt.wls),
    .par_even    (fmt.par_even),
    .par_stick   (fmt.par_stick),
    .data_masked (data_masked),
    .par_bit     (par_bit)
  );

  uft_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .tick        (baud_tick),
    .accept      (accept),
    .ld_data     (data_masked),
    .ld_last     (last_idx),
    .ld_par_en   (fmt.par_en),
    .ld_par_bit  (par_bit),
    .ld_two_stop (fmt.two_stop),
    .state_o     (state),
    .tx_line     (tx_line),
    .tx_busy     (tx_busy)
  );

  // R10: a word is only taken while no frame is running
  a_r10_accept_idle: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> !tx_busy);

  // R8: with gating on, a frame only begins if clear-to-send was active
  a_r8_cts_gate: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_busy) && $past(cfg_cts_en)) |-> $past(cts_ok));

  // R2: the line only moves on a baud tick
  a_r2_line_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$past(baud_tick) |-> $stable(tx_line));

  // R2: the line is high whenever no frame is running
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_line);

  // R10: busy ends on a tick, with the line at the stop level
  a_r10_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> ($past(baud_tick) && tx_line));

endmodule

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;

  localparam int TICK_DIV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_wls = '0;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_par_stick = 1'b0;
  logic       cfg_two_stop = 1'b0, cfg_cts_en = 1'b0, cts_ok = 1'b1;
  logic       tx_line, tx_busy;

  int n_chk = 0;
  int n_fail = 0;
  int tcnt = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    baud_tick <= (tcnt == 0);
    tcnt      <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
  end

  uart_frame_tx #(.DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .baud_tick(baud_tick), .cfg_wls(cfg_wls),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_two_stop(cfg_two_stop),
    .cfg_cts_en(cfg_cts_en), .cts_ok(cts_ok), .tx_line(tx_line),
    .tx_busy(tx_busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_tick();
    while (!baud_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_fmt(input [1:0] w, input bit pe, ev, st, two);
    cfg_wls = w; cfg_par_en = pe; cfg_par_even = ev;
    cfg_par_stick = st; cfg_two_stop = two;
  endtask

  // sends one word and checks every bit against a frame built from the rules
  task automatic send_frame(input [7:0] d, input [1:0] w, input bit pe, ev,
                            st, two, input bit align, input bit mid_change,
                            input bit cts_drop, input string req);
    logic exp_bits [0:11];
    int   n;
    int   nb;
    int   ones;
    logic pbit;
    nb = 5 + int'(w);
    ones = 0;
    n = 0;
    exp_bits[n++] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      exp_bits[n++] = d[i];
      ones += int'(d[i]);
    end
    if (pe) begin
      if (st) pbit = ev;
      else    pbit = ev ? ((ones % 2) == 1) : ((ones % 2) == 0);
      exp_bits[n++] = pbit;
    end
    exp_bits[n++] = 1'b1;
    if (two) exp_bits[n++] = 1'b1;

    @(negedge clk);
    set_fmt(w, pe, ev, st, two);
    in_data = d;
    if (align) while (!(baud_tick && in_ready)) @(negedge clk);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tx_busy == 1'b1, "R10", "busy after accept", int'(tx_busy), 1);
    chk(tx_line == 1'b1, "R2", "line high before start", int'(tx_line), 1);
    for (int k = 0; k < n; k++) begin
      wait_tick();
      chk(tx_line == exp_bits[k], req, $sformatf("bit %0d", k),
          int'(tx_line), int'(exp_bits[k]));
      chk(tx_busy && !in_ready, "R10", "busy/ready mid-frame",
          int'({tx_busy, in_ready}), 2);
      if (k == 1 && mid_change) begin
        in_data = ~d;
        set_fmt(~w, ~pe, ~ev, ~st, ~two);
      end
      if (k == 1 && cts_drop) cts_ok = 1'b0;
    end
    wait_tick();
    chk(tx_busy == 1'b0, "R10", "busy after last stop", int'(tx_busy), 0);
    chk(tx_line == 1'b1, "R2", "line high after frame", int'(tx_line), 1);
    set_fmt(2'b00, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_line == 1'b1, "R1", "reset line", int'(tx_line), 1);
    chk(tx_busy == 1'b0, "R1", "reset busy", int'(tx_busy), 0);
    chk(in_ready == 1'b1, "R1", "reset ready", int'(in_ready), 1);
  endtask

  task automatic t_default();
    send_frame(8'hA6, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_lengths();
    send_frame(8'h2D, 2'b01, 0, 0, 0, 0, 0, 0, 0, "R3");
    send_frame(8'h55, 2'b10, 0, 0, 0, 1, 0, 0, 0, "R3");
    send_frame(8'hC3, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R3");
    send_frame(8'hE0, 2'b00, 1, 1, 0, 0, 0, 0, 0, "R3");
  endtask

  task automatic t_parity();
    send_frame(8'h07, 2'b11, 1, 0, 0, 0, 0, 0, 0, "R5");
    send_frame(8'h07, 2'b11, 1, 1, 0, 0, 0, 0, 0, "R5");
    send_frame(8'h3C, 2'b10, 1, 0, 0, 1, 0, 0, 0, "R4");
    send_frame(8'h3C, 2'b11, 1, 1, 1, 0, 0, 0, 0, "R6");
    send_frame(8'h01, 2'b11, 1, 0, 1, 1, 0, 0, 0, "R6");
  endtask

  task automatic t_stops();
    send_frame(8'h9A, 2'b11, 0, 0, 0, 1, 0, 0, 0, "R7");
    send_frame(8'h9A, 2'b11, 1, 1, 0, 1, 0, 0, 0, "R7");
  endtask

  task automatic t_tick_align();
    send_frame(8'h5A, 2'b11, 1, 0, 0, 0, 1, 0, 0, "R2");
  endtask

  task automatic t_cts_block();
    @(negedge clk);
    cfg_cts_en = 1'b1;
    cts_ok = 1'b0;
    in_data = 8'h4B;
    in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_tick();
      chk(!in_ready && !tx_busy && tx_line, "R8", "held by cts",
          int'({in_ready, tx_busy, tx_line}), 1);
    end
    cts_ok = 1'b1;
    send_frame(8'h4B, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R8");
    cfg_cts_en = 1'b0;
  endtask

  task automatic t_cts_ignored();
    cts_ok = 1'b0;
    cfg_cts_en = 1'b0;
    send_frame(8'h96, 2'b10, 1, 1, 0, 0, 0, 0, 0, "R8");
    cts_ok = 1'b1;
  endtask

  task automatic t_cts_drop();
    cfg_cts_en = 1'b1;
    cts_ok = 1'b1;
    send_frame(8'hB4, 2'b11, 1, 0, 0, 1, 0, 0, 1, "R9");
    @(negedge clk);
    chk(in_ready == 1'b0, "R8", "ready low after drop", int'(in_ready), 0);
    cts_ok = 1'b1;
    cfg_cts_en = 1'b0;
  endtask

  task automatic t_mid_change();
    send_frame(8'h6C, 2'b01, 1, 0, 0, 0, 0, 1, 0, "R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default();
    t_lengths();
    t_parity();
    t_stops();
    t_tick_align();
    t_cts_block();
    t_cts_ignored();
    t_cts_drop();
    t_mid_change();
    repeat (4) @(posedge clk);
    report();
  end

endmodule